// File: doc/BRIEF.md
# Memory-Mapped Bus Decoder

This block sits between a CPU with a 16-bit address bus and the set of targets that share that bus in a handheld game console. Each CPU access is steered to exactly one target: cartridge ROM, video RAM, cartridge RAM, internal work RAM (including its mirror), sprite attribute memory, I/O registers, high RAM, or the single interrupt-enable register at the very top of the space. For the chosen target the block raises a one-hot select strobe and gives a target-local offset, a write flag and write data. It also returns that target's read data to the CPU.

The select, offset and write outputs are registered and appear one clock after the request is taken. The read-data multiplexer is combinational and is driven by the registered select. While a sprite-attribute DMA transfer is running, the CPU can reach only high RAM. Every other access during DMA gets no strobe, its write is dropped, and its read returns 0xFF. The hole between sprite attribute memory and I/O behaves in the same way at all times. A parameter chooses whether the echo region mirrors work RAM or is treated as a hole.

Top module: `mmio_bus_decoder`

## Requirements
- R1: An access to 0x0000–0x7FFF raises tgt_sel bit 0 (ROM) with offset = address[14:0], so offset bit 14 set marks the remappable upper 16 KiB window.
- R2: An access to 0x8000–0x9FFF raises tgt_sel bit 1 (video RAM) with offset = address − 0x8000.
- R3: An access to 0xA000–0xBFFF raises tgt_sel bit 2 (cartridge RAM) with offset = address − 0xA000.
- R4: An access to 0xC000–0xDFFF raises tgt_sel bit 3 (work RAM) with offset = address − 0xC000. With mirroring enabled (the default), 0xE000–0xFDFF also raises bit 3 with offset = address − 0xE000.
- R5: An access to 0xFE00–0xFE9F raises tgt_sel bit 4 (sprite attributes) with offset = address − 0xFE00. An access to 0xFEA0–0xFEFF raises no strobe and reads 0xFF.
- R6: 0xFF00–0xFF7F raises bit 5 (I/O, offset = address − 0xFF00). 0xFF80–0xFFFE raises bit 6 (high RAM, offset = address − 0xFF80). 0xFFFF raises bit 7 (interrupt enable, offset 0) and never bit 6.
- R7: Strobes appear one clock after the request cycle. At most one bit of tgt_sel is high. A cycle with no request, and the reset state, give tgt_sel = 0.
- R8: While dma_active is high with the request, only a high-RAM access (0xFF80–0xFFFE) is selected. Any other access gets tgt_sel = 0, tgt_we = 0 and read data 0xFF.
- R9: cpu_rdata equals lane i of tgt_rdata (bits 8i+7..8i) when tgt_sel bit i is high, and 0xFF when tgt_sel is zero.
- R10: tgt_we and tgt_wdata show the request's write flag and data in the same cycle as the strobe. tgt_we is high only together with a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req | input | 1 | CPU access request this cycle |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 16 | CPU byte address |
| cpu_wdata | input | 8 | CPU write data |
| dma_active | input | 1 | Sprite-attribute DMA in progress |
| tgt_rdata | input | 64 | Read data of the eight targets, lane i in bits 8i+7..8i |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| tgt_sel | output | 8 | One-hot target select, registered |
| tgt_off | output | 15 | Offset inside the selected target, registered |
| tgt_we | output | 1 | Write strobe for the selected target, registered |
| tgt_wdata | output | 8 | Write data for the selected target, registered |

## Verification
Address decoding and DMA gating act in the same cycle. An access to any region can arrive while dma_active is high, and then the gate must overrule the decode result. The bench first sweeps the full 64 KiB with DMA off, and then sweeps again with DMA on at a stride that lands on every region, including both edges of high RAM and the top address. For every access it computes the expected strobe, offset and read value from the address ranges alone. Writes made during DMA to blocked and to open regions check that only high-RAM writes reach tgt_we.

// File: rtl/mmio_dec_pkg.sv
package mmio_dec_pkg;
   localparam int NUM_TGT = 8;

   typedef enum logic [2:0] {
      TGT_ROM  = 3'd0,
      TGT_VRAM = 3'd1,
      TGT_CRAM = 3'd2,
      TGT_WRAM = 3'd3,
      TGT_OAM  = 3'd4,
      TGT_IO   = 3'd5,
      TGT_HRAM = 3'd6,
      TGT_IE   = 3'd7
   } tgt_e;
endpackage

// File: rtl/mmio_region_decode.sv
module mmio_region_decode
   import mmio_dec_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter bit MIRROR_EN = 1'b1,
   localparam int OFF_W    = ADDR_W - 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output tgt_e              idx,
   output logic [OFF_W-1:0]  off
);
   logic              echo_hit;
   logic [ADDR_W-1:0] base;

   generate
      if (MIRROR_EN) begin : g_echo_on
         assign echo_hit = (addr >= 16'hE000) && (addr < 16'hFE00);
      end else begin : g_echo_off
         assign echo_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      hit  = 1'b1;
      idx  = TGT_ROM;
      base = '0;
      if (addr < 16'h8000) begin
         idx = TGT_ROM;  base = 16'h0000;
      end else if (addr < 16'hA000) begin
         idx = TGT_VRAM; base = 16'h8000;
      end else if (addr < 16'hC000) begin
         idx = TGT_CRAM; base = 16'hA000;
      end else if (addr < 16'hE000) begin
         idx = TGT_WRAM; base = 16'hC000;
      end else if (echo_hit) begin
         idx = TGT_WRAM; base = 16'hE000;
      end else if (addr < 16'hFE00) begin
         hit = 1'b0;
      end else if (addr < 16'hFEA0) begin
         idx = TGT_OAM;  base = 16'hFE00;
      end else if (addr < 16'hFF00) begin
         hit = 1'b0;
      end else if (addr < 16'hFF80) begin
         idx = TGT_IO;   base = 16'hFF00;
      end else if (addr != 16'hFFFF) begin
         idx = TGT_HRAM; base = 16'hFF80;
      end else begin
         idx = TGT_IE;   base = 16'hFFFF;
      end
   end

   logic [ADDR_W-1:0] diff;
   assign diff = addr - base;
   assign off  = diff[OFF_W-1:0];
endmodule

// File: rtl/mmio_dma_gate.sv
module mmio_dma_gate
   import mmio_dec_pkg::*;
#(
   parameter int N = NUM_TGT
) (
   input  logic         req,
   input  logic         hit,
   input  tgt_e         idx,
   input  logic         dma_active,
   output logic [N-1:0] sel_next
);
   logic pass;
   assign pass = req && hit && (!dma_active || idx == TGT_HRAM);

   generate
      for (genvar i = 0; i < N; i++) begin : g_sel
         assign sel_next[i] = pass && (idx == tgt_e'(i));
      end
   endgenerate
endmodule

// File: rtl/mmio_rdata_mux.sv
module mmio_rdata_mux #(
   parameter int N      = 8,
   parameter int DATA_W = 8
) (
   input  logic [N-1:0]        sel,
   input  logic [N*DATA_W-1:0] lanes,
   output logic [DATA_W-1:0]   rdata
);
   logic [DATA_W-1:0] acc [N+1];
   assign acc[0] = '0;

   generate
      for (genvar i = 0; i < N; i++) begin : g_or
         assign acc[i+1] = acc[i] | ({DATA_W{sel[i]}} & lanes[i*DATA_W +: DATA_W]);
      end
   endgenerate

   assign rdata = (|sel) ? acc[N] : {DATA_W{1'b1}};
endmodule

// File: rtl/mmio_bus_decoder.sv
module mmio_bus_decoder
   import mmio_dec_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int DATA_W    = 8,
   parameter bit MIRROR_EN = 1'b1,
   localparam int OFF_W    = ADDR_W - 1,
   localparam int LANES_W  = NUM_TGT * DATA_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cpu_req,
   input  logic               cpu_we,
   input  logic [ADDR_W-1:0]  cpu_addr,
   input  logic [DATA_W-1:0]  cpu_wdata,
   input  logic               dma_active,
   input  logic [LANES_W-1:0] tgt_rdata,
   output logic [DATA_W-1:0]  cpu_rdata,
   output logic [NUM_TGT-1:0] tgt_sel,
   output logic [OFF_W-1:0]   tgt_off,
   output logic               tgt_we,
   output logic [DATA_W-1:0]  tgt_wdata
);
   initial begin
      assert (ADDR_W == 16) else $error("ADDR_W must be 16 for this map");
      assert (DATA_W >= 1)  else $error("DATA_W must be positive");
   end

   logic               dec_hit;
   tgt_e               dec_idx;
   logic [OFF_W-1:0]   dec_off;
   logic [NUM_TGT-1:0] sel_next;

   mmio_region_decode #(.ADDR_W(ADDR_W), .MIRROR_EN(MIRROR_EN)) u_dec (
      .addr (cpu_addr),
      .hit  (dec_hit),
      .idx  (dec_idx),
      .off  (dec_off)
   );

   mmio_dma_gate #(.N(NUM_TGT)) u_gate (
      .req        (cpu_req),
      .hit        (dec_hit),
      .idx        (dec_idx),
      .dma_active (dma_active),
      .sel_next   (sel_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tgt_sel   <= '0;
         tgt_off   <= '0;
         tgt_we    <= 1'b0;
         tgt_wdata <= '0;
      end else begin
         tgt_sel   <= sel_next;
         tgt_off   <= dec_off;
         tgt_we    <= cpu_we && (|sel_next);
         tgt_wdata <= cpu_wdata;
      end
   end

   mmio_rdata_mux #(.N(NUM_TGT), .DATA_W(DATA_W)) u_mux (
      .sel   (tgt_sel),
      .lanes (tgt_rdata),
      .rdata (cpu_rdata)
   );
endmodule

// File: rtl/mmio_bus_decoder_chk.sv
module mmio_bus_decoder_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        cpu_req,
   input logic        cpu_we,
   input logic [15:0] cpu_addr,
   input logic        dma_active,
   input logic [7:0]  cpu_rdata,
   input logic [7:0]  tgt_sel,
   input logic        tgt_we
);
   AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(tgt_sel)); // R7

   AST_IDLE_NO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      !cpu_req |=> tgt_sel == 8'h00); // R7

   AST_DMA_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && dma_active && (cpu_addr < 16'hFF80 || cpu_addr == 16'hFFFF))
      |=> (tgt_sel == 8'h00 && !tgt_we)); // R8

   AST_IE_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !dma_active && cpu_addr == 16'hFFFF) |=> tgt_sel == 8'h80); // R6

   AST_EMPTY_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_sel == 8'h00 |-> cpu_rdata == 8'hFF); // R9

   AST_WE_WITH_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_we |-> tgt_sel != 8'h00); // R10

   AST_WE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_req && !cpu_we) |=> !tgt_we); // R10
endmodule

bind mmio_bus_decoder mmio_bus_decoder_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cpu_req    (cpu_req),
   .cpu_we     (cpu_we),
   .cpu_addr   (cpu_addr),
   .dma_active (dma_active),
   .cpu_rdata  (cpu_rdata),
   .tgt_sel    (tgt_sel),
   .tgt_we     (tgt_we)
);

// File: tb/mmio_bus_decoder_bench.sv
module mmio_bus_decoder_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cpu_req = 1'b0;
   logic        cpu_we = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0;
   logic        dma_active = 1'b0;
   logic [63:0] tgt_rdata;
   logic [7:0]  cpu_rdata;
   logic [7:0]  tgt_sel;
   logic [14:0] tgt_off;
   logic        tgt_we;
   logic [7:0]  tgt_wdata;

   int n_chk = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   always_comb begin
      for (int i = 0; i < 8; i++) tgt_rdata[i*8 +: 8] = 8'(8'h11 * (i + 1));
   end

   mmio_bus_decoder u_mmio_bus_decoder (
      .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
      .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .dma_active(dma_active),
      .tgt_rdata(tgt_rdata), .cpu_rdata(cpu_rdata), .tgt_sel(tgt_sel),
      .tgt_off(tgt_off), .tgt_we(tgt_we), .tgt_wdata(tgt_wdata)
   );

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 199000 && !done) begin
         n_bad = n_bad + 1;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
         $finish;
      end
   end

   // Expected target index from the address map; -1 for none.
   function automatic int exp_idx(input logic [15:0] a, output logic [15:0] base,
                                  output string tag);
      base = 16'h0;
      if (a < 16'h8000)      begin tag = "R1"; base = 16'h0000; return 0; end
      else if (a < 16'hA000) begin tag = "R2"; base = 16'h8000; return 1; end
      else if (a < 16'hC000) begin tag = "R3"; base = 16'hA000; return 2; end
      else if (a < 16'hE000) begin tag = "R4"; base = 16'hC000; return 3; end
      else if (a < 16'hFE00) begin tag = "R4"; base = 16'hE000; return 3; end
      else if (a < 16'hFEA0) begin tag = "R5"; base = 16'hFE00; return 4; end
      else if (a < 16'hFF00) begin tag = "R5"; return -1; end
      else if (a < 16'hFF80) begin tag = "R6"; base = 16'hFF00; return 5; end
      else if (a < 16'hFFFF) begin tag = "R6"; base = 16'hFF80; return 6; end
      else                   begin tag = "R6"; base = 16'hFFFF; return 7; end
   endfunction

   task automatic do_access(input logic [15:0] a, input logic w, input logic d,
                            input logic [7:0] wd);
      logic [15:0] base;
      string       tag;
      int          idx;
      logic [7:0]  e_sel, e_rd;
      logic [14:0] e_off;
      logic        e_we, ok;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = w; cpu_addr = a; dma_active = d; cpu_wdata = wd;
      @(negedge clk);
      idx = exp_idx(a, base, tag);
      if (d && idx != 6) begin idx = -1; tag = "R8"; end
      if (w) tag = {tag, "/R10"};
      e_sel = (idx < 0) ? 8'h00 : 8'(1 << idx);
      e_off = 15'(a - base);
      e_rd  = (idx < 0) ? 8'hFF : 8'(8'h11 * (idx + 1));
      e_we  = w && (idx >= 0);
      ok = (tgt_sel == e_sel) && (cpu_rdata == e_rd) && (tgt_we == e_we)
           && (idx < 0 || tgt_off == e_off) && (!e_we || tgt_wdata == wd);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s addr=%h dma=%b sel=%h/%h off=%h/%h rdata(R9)=%h/%h we=%b/%b wd=%h/%h",
                  tag, a, d, tgt_sel, e_sel, tgt_off, e_off, cpu_rdata, e_rd,
                  tgt_we, e_we, tgt_wdata, wd);
      end
   endtask

   task automatic check_idle(input string tag);
      n_chk++;
      if (tgt_sel !== 8'h00 || cpu_rdata !== 8'hFF || tgt_we !== 1'b0) begin
         n_bad++;
         $display("FAIL %s idle sel=%h/00 rdata=%h/ff we=%b/0", tag, tgt_sel, cpu_rdata, tgt_we);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check_idle("R7 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_idle("R7 after reset");

      // Full map sweep, reads, DMA off: R1..R6, R9
      for (int a = 0; a < 65536; a++) do_access(16'(a), 1'b0, 1'b0, 8'h00);

      // Request dropped: R7
      cpu_req = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check_idle("R7 no request");

      // DMA sweep with stride, plus high-RAM edges and top address: R8
      for (int a = 0; a < 65536; a += 61) do_access(16'(a), 1'b0, 1'b1, 8'h00);
      do_access(16'hFF7F, 1'b0, 1'b1, 8'h00);
      do_access(16'hFF80, 1'b0, 1'b1, 8'h00);
      do_access(16'hFFFE, 1'b0, 1'b1, 8'h00);
      do_access(16'hFFFF, 1'b0, 1'b1, 8'h00);
      do_access(16'hFE00, 1'b0, 1'b1, 8'h00);

      // Writes: R10 normal, R8 dropped during DMA, high RAM still open
      do_access(16'h8123, 1'b1, 1'b0, 8'h5A);
      do_access(16'hC777, 1'b1, 1'b0, 8'hA5);
      do_access(16'hFF26, 1'b1, 1'b0, 8'h80);
      do_access(16'hFFFF, 1'b1, 1'b0, 8'h1F);
      do_access(16'hFEB0, 1'b1, 1'b0, 8'h33);
      do_access(16'hC777, 1'b1, 1'b1, 8'h44);
      do_access(16'hFE10, 1'b1, 1'b1, 8'h45);
      do_access(16'hFF90, 1'b1, 1'b1, 8'h46);
      do_access(16'hFFFF, 1'b1, 1'b1, 8'h47);

      cpu_req = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check_idle("R7 final idle");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule